// File: doc/BRIEF.md
# Link Pulse Watchdog Generator

This block keeps a 10BASE-T link alive by putting a short positive pulse on the differential transmit pair whenever the line has been quiet for one full idle interval. A prescaler and a period counter together form a watchdog. Each time the period counter wraps, a pulse shaper drives TX+ high for a fixed number of clock cycles while TX- stays low. The lines then return to the idle low state.

A frame controller raises `hold_i` for as long as a frame, and the idle signal that ends it, are on the wire. While `hold_i` is high, both counters are cleared and held. The idle interval therefore starts again from zero once the frame is finished. The shaper raises `busy_o` one cycle before the line is driven and drops it one cycle after the line is released. A frame serializer waits on this flag before it takes the line.

Both outputs are zero whenever no pulse is being driven, so they can be ORed with the serializer's outputs. With the default parameters and a 240 MHz clock, the interval is 64 × 60000 cycles, which is 16 ms and lies inside the required 16 ms ± 8 ms window. The default pulse width is 24 cycles, which is 100 ns.

Top module: `link_pulse_wdog`

## Requirements
- R1: After reset, `busy_o`, `tx_p_o` and `tx_n_o` are 0 and both counters are at zero and running. The first rise of `busy_o` follows the clock edge numbered PRESCALE×WRAP_COUNT, counting the first edge after reset release as edge 1.
- R2: While `hold_i` stays low, successive rises of `busy_o` are exactly PRESCALE×WRAP_COUNT clock cycles apart.
- R3: Each pulse holds `tx_p_o` at 1 for exactly PULSE_CYCLES consecutive cycles.
- R4: `busy_o` rises exactly one cycle before `tx_p_o` rises. `busy_o` falls exactly one cycle after `tx_p_o` falls. `tx_p_o` is never 1 while `busy_o` is 0.
- R5: `tx_n_o` is 0 at all times, both during a pulse and when the line is idle.
- R6: No pulse starts in a cycle in which `hold_i` is sampled high, so a rise of `busy_o` never follows an edge at which `hold_i` was 1.
- R7: Every edge at which `hold_i` is sampled high clears both counters. The next rise of `busy_o` therefore follows the edge PRESCALE×WRAP_COUNT cycles after the last such edge.
- R8: If `hold_i` rises while a pulse is in progress, that pulse still completes with the width and framing given in R3 and R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hold_i | input | 1 | Stop-and-clear request from the frame controller |
| busy_o | output | 1 | High while a link pulse owns the line, including one guard cycle before it and one after it |
| tx_p_o | output | 1 | TX+ drive; 1 only during the pulse |
| tx_n_o | output | 1 | TX- drive; always 0 |

## Verification
A free-running stretch checks the reset-to-first-pulse distance and the steady interval, which separates an off-by-one in the prescaler from one in the period counter. A sweep then raises `hold_i` at every phase offset inside one interval, each time with a different hold length. Offsets that fall inside a pulse show whether a hold truncates a pulse that has already started. Offsets in the quiet part show whether the counters are cleared, rather than only paused. A hold longer than a full interval shows that a wrap is suppressed, and is not merely deferred until after release. For every pulse, the bench measures the spacing between busy and line edges and the width of the drive on TX+.

// File: rtl/lpw_pkg.sv
`timescale 1ns/1ps
package lpw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_DRIVE = 2'd2,
    ST_TAIL  = 2'd3
  } shaper_state_e;
endpackage

// File: rtl/lpw_prescale.sv
`timescale 1ns/1ps
module lpw_prescale #(
  parameter int unsigned DIV = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = ~clear_i;
    end else begin : g_count
      localparam int unsigned CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (clear_i)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = ~clear_i & (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/lpw_period.sv
`timescale 1ns/1ps
module lpw_period #(
  parameter int unsigned WRAP = 60000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  output logic wrap_o
);
  localparam int unsigned CW = $clog2(WRAP + 1);
  localparam logic [CW-1:0] LAST = CW'(WRAP - 1);

  logic [CW-1:0] cnt_q;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (step_i)   cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end

  assign wrap_o = step_i & at_last & ~clear_i;
endmodule

// File: rtl/lpw_shaper.sv
`timescale 1ns/1ps
module lpw_shaper
  import lpw_pkg::*;
#(
  parameter int unsigned WIDTH = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic busy_o,
  output logic drive_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

  shaper_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (fire_i) state_d = ST_LEAD;
      ST_LEAD:  begin state_d = ST_DRIVE; cnt_d = '0; end
      ST_DRIVE: begin
        if (cnt_q == LAST) state_d = ST_TAIL;
        else               cnt_d = cnt_q + 1'b1;
      end
      ST_TAIL:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign drive_o = (state_q == ST_DRIVE);
endmodule

// File: rtl/link_pulse_wdog.sv
`timescale 1ns/1ps
module link_pulse_wdog #(
  parameter int unsigned PRESCALE     = 64,
  parameter int unsigned WRAP_COUNT   = 60000,
  parameter int unsigned PULSE_CYCLES = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic busy_o,
  output logic tx_p_o,
  output logic tx_n_o
);
  logic tick, wrap, fire, drive;

  lpw_prescale #(.DIV(PRESCALE)) u_prescale (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(hold_i), .tick_o(tick)
  );

  lpw_period #(.WRAP(WRAP_COUNT)) u_period (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(hold_i), .step_i(tick), .wrap_o(wrap)
  );

  // a wrap is dropped, not deferred, while the frame controller holds
  assign fire = wrap & ~hold_i;

  lpw_shaper #(.WIDTH(PULSE_CYCLES)) u_shaper (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .busy_o(busy_o), .drive_o(drive)
  );

  assign tx_p_o = drive;
  assign tx_n_o = 1'b0;
endmodule

// File: rtl/lpw_checker.sv
`timescale 1ns/1ps
module lpw_checker #(
  parameter int unsigned PULSE_CYCLES = 24
) (
  input logic clk_i,
  input logic rst_ni,
  input logic hold_i,
  input logic busy_o,
  input logic tx_p_o,
  input logic tx_n_o
);
  logic [15:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_q <= '0;
    else if (tx_p_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  AST_TXN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_n_o == 1'b0); // R5

  AST_DRIVE_OWNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_p_o |-> busy_o); // R4

  AST_BUSY_LEADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> tx_p_o); // R4

  AST_BUSY_TRAILS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_p_o) |-> (busy_o && $past(busy_o))); // R4

  AST_HOLD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !busy_o) |=> !busy_o); // R6

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_p_o) |-> (run_q == 16'(PULSE_CYCLES))); // R3
endmodule

bind link_pulse_wdog lpw_checker #(.PULSE_CYCLES(PULSE_CYCLES)) u_lpw_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i),
  .busy_o(busy_o), .tx_p_o(tx_p_o), .tx_n_o(tx_n_o)
);

// File: tb/link_pulse_wdog_bench.sv
`timescale 1ns/1ps
module link_pulse_wdog_bench;
  localparam int P  = 2;
  localparam int W  = 5;
  localparam int PW = 3;
  localparam int PERIOD = P * W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hold = 1'b0;
  logic busy, tx_p, tx_n;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int ref_cyc = 0;
  int rise_cnt = 0;
  int busy_rise = 0;
  int txp_rise = 0;
  int txp_fall = 0;
  logic hold_s = 1'b0;
  logic busy_prev = 1'b0;
  logic txp_prev = 1'b0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  link_pulse_wdog #(.PRESCALE(P), .WRAP_COUNT(W), .PULSE_CYCLES(PW)) u_link_pulse_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .hold_i(hold),
    .busy_o(busy), .tx_p_o(tx_p), .tx_n_o(tx_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // inputs change 2 ns after a rising edge, so a posedge sees the settled value
  always @(posedge clk) begin
    if (rst_ni) begin
      cyc++;
      hold_s = hold;
      if (hold) ref_cyc = cyc; // R7: counters cleared at this edge
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      chk("R5 tx_n low", int'(tx_n), 0);
      if (tx_p) chk("R4 drive only while busy", int'(busy), 1);
      if (busy && !busy_prev) begin
        chk("R2/R7 busy rise cycle", cyc, ref_cyc + PERIOD);
        chk("R6 no start under hold", int'(hold_s), 0);
        ref_cyc = cyc;
        busy_rise = cyc;
        rise_cnt++;
      end
      if (tx_p && !txp_prev) begin
        chk("R4 busy leads drive by one", cyc - busy_rise, 1);
        txp_rise = cyc;
      end
      if (!tx_p && txp_prev) begin
        chk("R3/R8 pulse width", cyc - txp_rise, PW);
        txp_fall = cyc;
      end
      if (!busy && busy_prev)
        chk("R4 busy trails drive by one", cyc - txp_fall, 1);
      busy_prev = busy;
      txp_prev  = tx_p;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wait_rise();
    int n;
    n = rise_cnt;
    wait (rise_cnt != n);
    @(posedge clk);
    #2;
  endtask

  initial begin
    int r0;
    #3;
    chk("R1 reset busy", int'(busy), 0);
    chk("R1 reset tx_p", int'(tx_p), 0);
    chk("R1 reset tx_n", int'(tx_n), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    // R1 first pulse at edge PERIOD, then R2 steady spacing
    wait (rise_cnt == 1);
    chk("R1 first rise cycle", busy_rise, PERIOD);
    wait (rise_cnt == 4);
    step(1);
    // R6/R7/R8 sweep of hold onset across every phase of an interval
    for (int off = 0; off < PERIOD + 2; off++) begin
      wait_rise();
      if (off > 0) step(off);
      hold = 1'b1;
      step(1 + (off % 4));
      hold = 1'b0;
    end
    // long hold: R6 a wrap must not fire or be deferred
    wait_rise();
    step(PW + 3);
    hold = 1'b1;
    r0 = rise_cnt;
    step(3 * PERIOD);
    chk("R6 no pulse during long hold", rise_cnt - r0, 0);
    hold = 1'b0;
    step(2 * PERIOD + 2);
    chk("R7 pulses resume after release", (rise_cnt - r0 >= 2) ? 1 : 0, 1);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule